// File: doc/BRIEF.md
# Token Boundary Aligner

The block lines up a text stream with a separate stream of token position pairs. Each pair gives the first and the last character position of one token. A running character pointer counts the characters accepted since the start of the current document. Every character leaves the block tagged with its position and two flags. One flag marks the first character of a token and the other marks the last character. Downstream single-token matchers use these flags as their only start and reset control. Token edges are never inferred from the text itself.

One pair is held at a time. The block loads a pair only while it holds none, and it frees the held pair once the token's last character has gone out. It accepts no character while no pair is held, so no character can pass a token edge unmarked. A pair that starts behind the pointer, or that ends before it starts, is flagged and dropped. A document-start input clears the pointer and drops the held pair. Output can be registered or combinational, chosen by a parameter.

Top module: `tok_bound_align`

## Requirements
- R1: After reset, `ch_ready` and `mk_valid` are 0, `pr_ready` is 1, and the pointer is 0.
- R2: Characters come out in the order they were accepted, unchanged. Each carries in `mk_pos` the number of characters accepted before it since the last document start or reset, so the first one has position 0.
- R3: `mk_sot` is 1 exactly for the character whose position equals the held pair's start.
- R4: `mk_eot` is 1 exactly for the character whose position equals the held pair's end, so the end is inclusive. A one-character token (start equal to end) sets `mk_sot` and `mk_eot` on the same character. The pointer never moves past the held end.
- R5: Characters accepted while a pair is held but before its start position come out with both flags at 0.
- R6: While no pair is held, `ch_ready` is 0 and the pointer does not move.
- R7: `pr_ready` is 1 exactly when no pair is held and `doc_start` is 0. The cycle after the end character is accepted, the slot is empty again.
- R8: A pair accepted with start below the pointer, or with end below start, raises `pr_reject` in its handshake cycle and is not loaded. `pr_ready` stays 1 afterwards.
- R9: In a cycle with `doc_start` at 1, both readies are 0. In the next cycle the pointer is 0 and no pair is held, so the next character comes out at position 0.
- R10: With `OUT_REG` = 1 (the default), a character comes out one cycle after its handshake. `mk_tok_start` and `mk_tok_end` then show the pair it was checked against, and both flags are 0 whenever `mk_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| doc_start | input | 1 | Clears the pointer and drops the held pair |
| ch_valid | input | 1 | Character offered |
| ch_ready | output | 1 | Character taken this cycle if valid |
| ch_data | input | CHAR_W | Character value |
| pr_valid | input | 1 | Position pair offered |
| pr_ready | output | 1 | Pair taken this cycle if valid |
| pr_start | input | OFS_W | First character position of the token |
| pr_end | input | OFS_W | Last character position of the token (inclusive) |
| pr_reject | output | 1 | Pair taken this cycle was out of order and dropped |
| mk_valid | output | 1 | Tagged character present |
| mk_char | output | CHAR_W | Character value |
| mk_sot | output | 1 | First character of a token |
| mk_eot | output | 1 | Last character of a token |
| mk_pos | output | OFS_W | Character position |
| mk_tok_start | output | OFS_W | Start of the pair held for this character |
| mk_tok_end | output | OFS_W | End of the pair held for this character |

## Verification
The pair stream mixes ordered tokens of length one to five, with gaps of zero to three characters, and two kinds of bad pair. A pair that starts one position behind the pointer tells a correct compare against the pointer from a compare against the previous end. A pair that ends before it starts exercises the second rejection rule. Random valid gaps on both streams separate the stall when no pair is held from plain source idleness. Zero-length gaps and one-character tokens test the inclusive end and back-to-back flags. Document starts that fall mid-token check that the pointer and the held pair are both cleared.

// File: rtl/tba_pkg.sv
package tba_pkg;
   typedef enum logic {
      SLOT_EMPTY = 1'b0,
      SLOT_HELD  = 1'b1
   } slot_e;
endpackage

// File: rtl/tba_pointer.sv
module tba_pointer #(
   parameter int OFS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [OFS_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (clear) ptr <= '0;
      else if (step)  ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/tba_slot.sv
module tba_slot
   import tba_pkg::*;
#(
   parameter int OFS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             in_valid,
   input  logic [OFS_W-1:0] in_start,
   input  logic [OFS_W-1:0] in_end,
   input  logic [OFS_W-1:0] ptr,
   input  logic             consume,
   output logic             in_ready,
   output logic             reject,
   output logic             held,
   output logic [OFS_W-1:0] tok_start,
   output logic [OFS_W-1:0] tok_end
);
   slot_e state;
   logic  take;
   logic  bad;

   assign in_ready = (state == SLOT_EMPTY) && !clear;
   assign take     = in_valid && in_ready;
   assign bad      = (in_start < ptr) || (in_end < in_start);
   assign reject   = take && bad;
   assign held     = (state == SLOT_HELD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SLOT_EMPTY;
         tok_start <= '0;
         tok_end   <= '0;
      end else if (clear) begin
         state <= SLOT_EMPTY;
      end else if (take && !bad) begin
         state     <= SLOT_HELD;
         tok_start <= in_start;
         tok_end   <= in_end;
      end else if (consume) begin
         state <= SLOT_EMPTY;
      end
   end

   // R8: a dropped pair leaves the slot empty
   p_reject_keeps_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> (state == SLOT_EMPTY));

   // R4: the pointer never runs past the held end
   p_ptr_within_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> (ptr <= tok_end));
endmodule

// File: rtl/tba_outstage.sv
module tba_outstage #(
   parameter int CHAR_W  = 8,
   parameter int OFS_W   = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_char,
   input  logic              in_sot,
   input  logic              in_eot,
   input  logic [OFS_W-1:0]  in_pos,
   input  logic [OFS_W-1:0]  in_ts,
   input  logic [OFS_W-1:0]  in_te,
   output logic              o_valid,
   output logic [CHAR_W-1:0] o_char,
   output logic              o_sot,
   output logic              o_eot,
   output logic [OFS_W-1:0]  o_pos,
   output logic [OFS_W-1:0]  o_ts,
   output logic [OFS_W-1:0]  o_te
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_valid <= 1'b0;
               o_sot   <= 1'b0;
               o_eot   <= 1'b0;
               o_char  <= '0;
               o_pos   <= '0;
               o_ts    <= '0;
               o_te    <= '0;
            end else begin
               o_valid <= in_valid;
               o_sot   <= in_valid && in_sot;
               o_eot   <= in_valid && in_eot;
               if (in_valid) begin
                  o_char <= in_char;
                  o_pos  <= in_pos;
                  o_ts   <= in_ts;
                  o_te   <= in_te;
               end
            end
         end
      end else begin : g_comb
         assign o_valid = in_valid;
         assign o_sot   = in_valid && in_sot;
         assign o_eot   = in_valid && in_eot;
         assign o_char  = in_char;
         assign o_pos   = in_pos;
         assign o_ts    = in_ts;
         assign o_te    = in_te;
      end
   endgenerate

   // R10: no token flag without a character
   p_flags_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !o_valid |-> (!o_sot && !o_eot));
endmodule

// File: rtl/tok_bound_align.sv
module tok_bound_align #(
   parameter int CHAR_W  = 8,
   parameter int OFS_W   = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              doc_start,
   input  logic              ch_valid,
   output logic              ch_ready,
   input  logic [CHAR_W-1:0] ch_data,
   input  logic              pr_valid,
   output logic              pr_ready,
   input  logic [OFS_W-1:0]  pr_start,
   input  logic [OFS_W-1:0]  pr_end,
   output logic              pr_reject,
   output logic              mk_valid,
   output logic [CHAR_W-1:0] mk_char,
   output logic              mk_sot,
   output logic              mk_eot,
   output logic [OFS_W-1:0]  mk_pos,
   output logic [OFS_W-1:0]  mk_tok_start,
   output logic [OFS_W-1:0]  mk_tok_end
);
   generate
      if (CHAR_W < 1 || OFS_W < 2) begin : g_bad_width
         $error("tok_bound_align: CHAR_W must be >= 1 and OFS_W >= 2");
      end
   endgenerate

   logic             held;
   logic             accept;
   logic             at_start;
   logic             at_end;
   logic [OFS_W-1:0] ptr;
   logic [OFS_W-1:0] tok_s;
   logic [OFS_W-1:0] tok_e;

   assign ch_ready = held && !doc_start;
   assign accept   = ch_valid && ch_ready;
   assign at_start = held && (ptr == tok_s);
   assign at_end   = held && (ptr == tok_e);

   tba_pointer #(.OFS_W(OFS_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (doc_start),
      .step  (accept),
      .ptr   (ptr)
   );

   tba_slot #(.OFS_W(OFS_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (doc_start),
      .in_valid  (pr_valid),
      .in_start  (pr_start),
      .in_end    (pr_end),
      .ptr       (ptr),
      .consume   (accept && at_end),
      .in_ready  (pr_ready),
      .reject    (pr_reject),
      .held      (held),
      .tok_start (tok_s),
      .tok_end   (tok_e)
   );

   tba_outstage #(.CHAR_W(CHAR_W), .OFS_W(OFS_W), .OUT_REG(OUT_REG)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (accept),
      .in_char  (ch_data),
      .in_sot   (at_start),
      .in_eot   (at_end),
      .in_pos   (ptr),
      .in_ts    (tok_s),
      .in_te    (tok_e),
      .o_valid  (mk_valid),
      .o_char   (mk_char),
      .o_sot    (mk_sot),
      .o_eot    (mk_eot),
      .o_pos    (mk_pos),
      .o_ts     (mk_tok_start),
      .o_te     (mk_tok_end)
   );

   // R7: accepting the end character frees the slot
   p_eot_frees_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && at_end) |=> !held);

   // R9: document start clears pointer and slot
   p_doc_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      doc_start |=> ((ptr == '0) && !held));

   // R6: with no pair held the pointer stays put
   p_ptr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!held && !doc_start) |=> $stable(ptr));
endmodule

// File: tb/tok_bound_align_bench.sv
`timescale 1ns/1ps
module tok_bound_align_bench;
   localparam int CW = 8;
   localparam int OW = 32;
   localparam int CYCLES = 4000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          doc_start;
   logic          ch_valid;
   logic          ch_ready;
   logic [CW-1:0] ch_data;
   logic          pr_valid;
   logic          pr_ready;
   logic [OW-1:0] pr_start;
   logic [OW-1:0] pr_end;
   logic          pr_reject;
   logic          mk_valid;
   logic [CW-1:0] mk_char;
   logic          mk_sot;
   logic          mk_eot;
   logic [OW-1:0] mk_pos;
   logic [OW-1:0] mk_tok_start;
   logic [OW-1:0] mk_tok_end;

   always #2.5 clk = ~clk;

   tok_bound_align u_tok_bound_align (
      .clk(clk), .rst_n(rst_n), .doc_start(doc_start),
      .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_data(ch_data),
      .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_start(pr_start),
      .pr_end(pr_end), .pr_reject(pr_reject),
      .mk_valid(mk_valid), .mk_char(mk_char), .mk_sot(mk_sot),
      .mk_eot(mk_eot), .mk_pos(mk_pos), .mk_tok_start(mk_tok_start),
      .mk_tok_end(mk_tok_end)
   );

   typedef struct {
      logic [CW-1:0] c;
      logic [OW-1:0] pos;
      logic [OW-1:0] s;
      logic [OW-1:0] e;
      bit            sot;
      bit            eot;
   } ev_t;

   ev_t           q[$];
   int            n_chk = 0;
   int            n_fail = 0;
   bit            done = 1'b0;
   bit            m_held;
   logic [OW-1:0] m_s, m_e, m_cnt;
   bit            after_doc;
   bit            ch_took, pr_took;
   logic [OW-1:0] g_next;
   int            n_rej = 0, n_single = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit pair_bad(input logic [OW-1:0] s, input logic [OW-1:0] e,
                                   input logic [OW-1:0] p);
      return (s < p) || (e < s);
   endfunction

   task automatic new_pair();
      int kind = $urandom % 8;
      if (kind == 0 && g_next > 0) begin
         pr_start = g_next - 1;
         pr_end   = g_next + 2;
      end else if (kind == 1) begin
         pr_start = g_next + 2;
         pr_end   = g_next + 1;
      end else begin
         pr_start = g_next + ($urandom % 4);
         pr_end   = pr_start + ($urandom % 5);
         g_next   = pr_end + 1;
      end
      pr_valid = 1'b1;
   endtask

   task automatic step();
      ev_t ev;
      if (mk_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R2", "unexpected output", 1, 0);
         end else begin
            ev = q.pop_front();
            chk(mk_char == ev.c, "R2", "char", mk_char, ev.c);
            chk(mk_pos == ev.pos, "R2", "pos", mk_pos, ev.pos);
            chk(mk_sot == ev.sot, "R3", "sot", mk_sot, ev.sot);
            chk(mk_eot == ev.eot, "R4", "eot", mk_eot, ev.eot);
            if (ev.sot && ev.eot) n_single++;
            if (!ev.sot && !ev.eot)
               chk(!mk_sot && !mk_eot, "R5", "gap flags", {mk_sot, mk_eot}, 0);
            chk(mk_tok_start == ev.s, "R10", "tok_start", mk_tok_start, ev.s);
            chk(mk_tok_end == ev.e, "R10", "tok_end", mk_tok_end, ev.e);
            if (after_doc) chk(mk_pos == 0, "R9", "first pos after doc", mk_pos, 0);
            after_doc = 1'b0;
         end
      end else begin
         chk(!mk_sot && !mk_eot, "R10", "flags without valid", {mk_sot, mk_eot}, 0);
      end
      ch_took = 1'b0;
      pr_took = 1'b0;
      if (doc_start) begin
         chk(ch_ready == 1'b0, "R9", "ch_ready in doc_start", ch_ready, 0);
         chk(pr_ready == 1'b0, "R9", "pr_ready in doc_start", pr_ready, 0);
         m_held = 1'b0;
         m_cnt = '0;
         after_doc = 1'b1;
      end else begin
         chk(ch_ready == m_held, "R6", "ch_ready", ch_ready, m_held);
         chk(pr_ready == !m_held, "R7", "pr_ready", pr_ready, !m_held);
         if (pr_valid && pr_ready) begin
            bit bad = pair_bad(pr_start, pr_end, m_cnt);
            pr_took = 1'b1;
            chk(pr_reject == bad, "R8", "reject", pr_reject, bad);
            if (bad) n_rej++;
            else begin
               m_held = 1'b1;
               m_s = pr_start;
               m_e = pr_end;
            end
         end else begin
            chk(pr_reject == 1'b0, "R8", "idle reject", pr_reject, 0);
         end
         if (ch_valid && ch_ready) begin
            ch_took = 1'b1;
            ev.c = ch_data;
            ev.pos = m_cnt;
            ev.s = m_s;
            ev.e = m_e;
            ev.sot = (m_cnt == m_s);
            ev.eot = (m_cnt == m_e);
            q.push_back(ev);
            if (ev.eot) m_held = 1'b0;
            m_cnt = m_cnt + 1;
         end
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      rst_n = 1'b0;
      doc_start = 1'b0;
      ch_valid = 1'b0;
      ch_data = '0;
      pr_valid = 1'b0;
      pr_start = '0;
      pr_end = '0;
      m_held = 1'b0;
      m_s = '0;
      m_e = '0;
      m_cnt = '0;
      after_doc = 1'b1;
      ch_took = 1'b0;
      pr_took = 1'b0;
      g_next = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(ch_ready == 1'b0, "R1", "ch_ready after reset", ch_ready, 0);
      chk(pr_ready == 1'b1, "R1", "pr_ready after reset", pr_ready, 1);
      chk(mk_valid == 1'b0, "R1", "mk_valid after reset", mk_valid, 0);

      for (int cyc = 0; cyc < CYCLES; cyc++) begin
         @(posedge clk);
         #1;
         if (pr_took) pr_valid = 1'b0;
         if (cyc % 700 == 699) begin
            doc_start = 1'b1;
            ch_valid = 1'b0;
            pr_valid = 1'b0;
            g_next = '0;
         end else begin
            doc_start = 1'b0;
            if (!pr_valid && ($urandom % 4 != 0)) new_pair();
            if (!ch_valid || ch_took) ch_data = CW'($urandom);
            ch_valid = ($urandom % 5 != 0);
         end
         @(negedge clk);
         step();
      end

      @(posedge clk);
      #1;
      doc_start = 1'b0;
      ch_valid = 1'b0;
      pr_valid = 1'b0;
      repeat (2) begin
         @(negedge clk);
         step();
      end
      chk(q.size() == 0, "R2", "outputs left undelivered", q.size(), 0);
      chk(n_rej > 0, "R8", "bad pairs exercised", n_rej > 0, 1);
      chk(n_single > 0, "R4", "one-char tokens exercised", n_single > 0, 1);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule